// File: doc/BRIEF.md
# Two-Region Block Erase Sequencer

This block takes one erase request, given as a start byte address and a byte length, for a flash array whose address space is split into two erase regions. The lower region is made of small blocks and the upper region of large blocks. The block first checks the request. The range must lie inside the device. The start address must sit on a block boundary of the region that holds it. The end address (start plus length) must sit on a block boundary of the region that holds that address.

If the request passes these checks, the block walks the range from the lowest address upward. It hands one block-erase command to a downstream engine through a request/acknowledge handshake. Each acknowledge carries a fail flag. After each block the address steps forward by the block size of the region it is in. The step grows when the walk passes into the upper region. The walk ends with one of three sticky status flags: done, invalid, or failed.

With the default parameters, the lower region holds 8 blocks of 16 KiB (0x000000 to 0x01FFFF). The upper region holds 31 blocks of 128 KiB, from 0x020000 to 0x3FFFFF, so the device holds 4 MiB in total.

Top module: `erase_walker`

## Requirements
- R1: A request is accepted only in a cycle where `reqValid` and `reqReady` are both high. If `reqStart + reqLen` (computed without overflow) exceeds the device size of 0x400000, the request sets `statusInvalid` on the next edge and issues no erase.
- R2: A start address below 0x20000 must be a multiple of 0x4000. A start address at or above 0x20000 must be a multiple of 0x20000. Otherwise `statusInvalid` is set and no erase is issued.
- R3: The end address `reqStart + reqLen` must also be aligned. An end below 0x20000 must be a multiple of 0x4000. An end at or above 0x20000, including exactly 0x20000, must be a multiple of 0x20000. Otherwise `statusInvalid` is set and no erase is issued.
- R4: A valid request with nonzero length raises `eraseReq` on the edge that accepts it, with `eraseAddr = reqStart`. It then issues exactly one command per block, at strictly ascending addresses, and every command address is aligned to its region's block size.
- R5: After a block at an address below 0x20000, the next command address is 0x4000 higher. After a block at or above 0x20000, the next command address is 0x20000 higher.
- R6: An acknowledge with `eraseFail` high ends the walk at that edge. `statusFailed` is set, and no further command is issued, even when that block was the last one.
- R7: When the last block is acknowledged without fail, `statusDone` is set and `reqReady` returns high on that edge.
- R8: A valid request of zero length sets `statusDone` on the accepting edge and issues no erase.
- R9: At most one status flag is high at any time. The flags hold their value until the next request is accepted, and an accepted request clears them.
- R10: While `eraseReq` is high and not yet acknowledged, it stays high and `eraseAddr` stays stable. `reqReady` is low throughout a walk.
- R11: After reset, `reqReady` is high and `eraseReq` and all status flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Erase request offered |
| reqStart | input | 32 | Request start byte address |
| reqLen | input | 32 | Request length in bytes |
| reqReady | output | 1 | Idle and able to accept a request |
| eraseReq | output | 1 | Block-erase command to the engine |
| eraseAddr | output | 32 | Base address of the block to erase |
| eraseAck | input | 1 | Engine finished the current block |
| eraseFail | input | 1 | Qualifies `eraseAck`: the block erase failed |
| statusDone | output | 1 | Last walk completed without error |
| statusInvalid | output | 1 | Last request was rejected |
| statusFailed | output | 1 | Last walk stopped on a failed block |

## Verification
Two events can meet on a single clock edge: a failing acknowledge and the end of the walk on its final block. The bench provokes this by failing the last block of both a single-block request and a request that crosses the region boundary. It judges the result by requiring `statusFailed` alone, with `statusDone` low and the command count equal to the number of blocks. Random requests built from block-aligned starts and block sums are mixed with deliberately misaligned ends and with ends that land exactly on the region boundary. The acknowledge arrives after a random delay, which checks that the command stays stable while it waits.

// File: rtl/ew_pkg.sv
package ew_pkg;
  typedef enum logic {EW_IDLE = 1'b0, EW_WALK = 1'b1} ewState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic load;
    logic step;
  } ewStrobe_t;

  // datapath -> control flags
  typedef struct packed {
    logic reqOk;
    logic lenZero;
    logic lastBlk;
  } ewFlag_t;
endpackage

// File: rtl/ew_datapath.sv
module ew_datapath
  import ew_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SMALL_BLK = 16384,
  parameter int SMALL_NUM = 8,
  parameter int BIG_BLK   = 131072,
  parameter int BIG_NUM   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ewStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [ADDR_W-1:0] reqLen,
  output ewFlag_t           flag,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int SUM_W = ADDR_W + 1;
  localparam longint BOUND_L = longint'(SMALL_BLK) * longint'(SMALL_NUM);
  localparam longint TOTAL_L = BOUND_L + longint'(BIG_BLK) * longint'(BIG_NUM);
  localparam logic [SUM_W-1:0] BOUND  = SUM_W'(BOUND_L);
  localparam logic [SUM_W-1:0] TOTAL  = SUM_W'(TOTAL_L);
  localparam logic [SUM_W-1:0] SMALLW = SUM_W'(SMALL_BLK);
  localparam logic [SUM_W-1:0] BIGW   = SUM_W'(BIG_BLK);

  // block size of the region holding an address
  function automatic logic [SUM_W-1:0] blkFor(input logic [SUM_W-1:0] a);
    return (a < BOUND) ? SMALLW : BIGW;
  endfunction

  function automatic logic onBoundary(input logic [SUM_W-1:0] a);
    return (a & (blkFor(a) - 1'b1)) == '0;
  endfunction

  logic [ADDR_W-1:0] remLen;
  logic [SUM_W-1:0]  endAddr;
  logic [SUM_W-1:0]  curBlk;

  assign endAddr = {1'b0, reqStart} + {1'b0, reqLen};
  assign curBlk  = blkFor({1'b0, curAddr});

  assign flag.reqOk   = (endAddr <= TOTAL) && onBoundary({1'b0, reqStart})
                        && onBoundary(endAddr);
  assign flag.lenZero = (reqLen == '0);
  assign flag.lastBlk = ({1'b0, remLen} <= curBlk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr <= '0;
      remLen  <= '0;
    end else if (strobe.load) begin
      curAddr <= reqStart;
      remLen  <= reqLen;
    end else if (strobe.step) begin
      curAddr <= curAddr + curBlk[ADDR_W-1:0];
      remLen  <= remLen - curBlk[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/ew_control.sv
module ew_control
  import ew_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      reqValid,
  input  logic      eraseAck,
  input  logic      eraseFail,
  input  ewFlag_t   flag,
  output ewStrobe_t strobe,
  output logic      reqReady,
  output logic      eraseReq,
  output logic      statusDone,
  output logic      statusInvalid,
  output logic      statusFailed
);
  ewState_t state, stateNext;
  logic     accept, ackNow;
  logic     doneNext, invalidNext, failedNext;

  assign reqReady = (state == EW_IDLE);
  assign eraseReq = (state == EW_WALK);
  assign accept   = reqValid && reqReady;
  assign ackNow   = eraseReq && eraseAck;

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    doneNext    = statusDone;
    invalidNext = statusInvalid;
    failedNext  = statusFailed;
    if (accept) begin
      strobe.load = 1'b1;
      doneNext    = 1'b0;
      invalidNext = 1'b0;
      failedNext  = 1'b0;
      if (!flag.reqOk)        invalidNext = 1'b1;
      else if (flag.lenZero)  doneNext    = 1'b1;
      else                    stateNext   = EW_WALK;
    end else if (ackNow) begin
      if (eraseFail) begin
        failedNext = 1'b1;
        stateNext  = EW_IDLE;
      end else begin
        strobe.step = 1'b1;
        if (flag.lastBlk) begin
          doneNext  = 1'b1;
          stateNext = EW_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= EW_IDLE;
      statusDone    <= 1'b0;
      statusInvalid <= 1'b0;
      statusFailed  <= 1'b0;
    end else begin
      state         <= stateNext;
      statusDone    <= doneNext;
      statusInvalid <= invalidNext;
      statusFailed  <= failedNext;
    end
  end
endmodule

// File: rtl/erase_walker.sv
module erase_walker
  import ew_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SMALL_BLK = 16384,
  parameter int SMALL_NUM = 8,
  parameter int BIG_BLK   = 131072,
  parameter int BIG_NUM   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqStart,
  input  logic [ADDR_W-1:0] reqLen,
  output logic              reqReady,
  output logic              eraseReq,
  output logic [ADDR_W-1:0] eraseAddr,
  input  logic              eraseAck,
  input  logic              eraseFail,
  output logic              statusDone,
  output logic              statusInvalid,
  output logic              statusFailed
);
  ewStrobe_t strobe;
  ewFlag_t   flag;

  ew_datapath #(
    .ADDR_W(ADDR_W), .SMALL_BLK(SMALL_BLK), .SMALL_NUM(SMALL_NUM),
    .BIG_BLK(BIG_BLK), .BIG_NUM(BIG_NUM)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .reqStart(reqStart), .reqLen(reqLen),
    .flag(flag), .curAddr(eraseAddr)
  );

  ew_control u_ctl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .eraseAck(eraseAck), .eraseFail(eraseFail), .flag(flag),
    .strobe(strobe), .reqReady(reqReady), .eraseReq(eraseReq),
    .statusDone(statusDone), .statusInvalid(statusInvalid),
    .statusFailed(statusFailed)
  );
endmodule

// File: rtl/ew_checker.sv
module ew_checker #(
  parameter int ADDR_W    = 32,
  parameter int SMALL_BLK = 16384,
  parameter int SMALL_NUM = 8,
  parameter int BIG_BLK   = 131072,
  parameter int BIG_NUM   = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqStart,
  input logic [ADDR_W-1:0] reqLen,
  input logic              reqReady,
  input logic              eraseReq,
  input logic [ADDR_W-1:0] eraseAddr,
  input logic              eraseAck,
  input logic              eraseFail,
  input logic              statusDone,
  input logic              statusInvalid,
  input logic              statusFailed
);
  localparam longint BOUND_L = longint'(SMALL_BLK) * longint'(SMALL_NUM);
  localparam longint TOTAL_L = BOUND_L + longint'(BIG_BLK) * longint'(BIG_NUM);

  logic [ADDR_W:0] reqEnd;
  logic            cmdAligned;
  assign reqEnd = {1'b0, reqStart} + {1'b0, reqLen};
  assign cmdAligned = (longint'(eraseAddr) < BOUND_L)
                      ? (eraseAddr % ADDR_W'(SMALL_BLK) == '0)
                      : (eraseAddr % ADDR_W'(BIG_BLK) == '0);

  assert_oversize_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && longint'(reqEnd) > TOTAL_L)
      |=> (statusInvalid && !eraseReq));

  assert_cmd_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |-> cmdAligned);

  assert_fail_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseReq && eraseAck && eraseFail)
      |=> (statusFailed && !statusDone && !eraseReq));

  assert_status_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({statusDone, statusInvalid, statusFailed}));

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && !reqValid)
      |=> $stable({statusDone, statusInvalid, statusFailed}));

  assert_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseReq && !eraseAck) |=> (eraseReq && $stable(eraseAddr)));

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eraseReq |-> !reqReady);
endmodule

bind erase_walker ew_checker #(
  .ADDR_W(ADDR_W), .SMALL_BLK(SMALL_BLK), .SMALL_NUM(SMALL_NUM),
  .BIG_BLK(BIG_BLK), .BIG_NUM(BIG_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqStart(reqStart),
  .reqLen(reqLen), .reqReady(reqReady), .eraseReq(eraseReq),
  .eraseAddr(eraseAddr), .eraseAck(eraseAck), .eraseFail(eraseFail),
  .statusDone(statusDone), .statusInvalid(statusInvalid),
  .statusFailed(statusFailed)
);

// File: tb/sim_erase_walker.sv
module sim_erase_walker;
  localparam longint BOUND = 64'h20000;
  localparam longint TOTAL = 64'h400000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqStart = '0;
  logic [31:0] reqLen = '0;
  logic        reqReady, eraseReq, statusDone, statusInvalid, statusFailed;
  logic [31:0] eraseAddr;
  logic        eraseAck = 1'b0;
  logic        eraseFail = 1'b0;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  erase_walker u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqStart(reqStart),
    .reqLen(reqLen), .reqReady(reqReady), .eraseReq(eraseReq),
    .eraseAddr(eraseAddr), .eraseAck(eraseAck), .eraseFail(eraseFail),
    .statusDone(statusDone), .statusInvalid(statusInvalid),
    .statusFailed(statusFailed)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint blk(input longint a);
    return (a < BOUND) ? 64'h4000 : 64'h20000;
  endfunction

  function automatic bit reqValidModel(input longint s, input longint l);
    longint e = s + l;
    return (e <= TOTAL) && (s % blk(s) == 0) && (e % blk(e) == 0);
  endfunction

  function automatic int blockCount(input longint s, input longint l);
    longint a = s;
    int n = 0;
    while (a < s + l) begin
      a += blk(a);
      n++;
    end
    return n;
  endfunction

  // failAt: index of block to fail, -1 for none
  task automatic doReq(input longint s, input longint l, input int failAt, input string tag);
    bit ok = reqValidModel(s, l);
    int expN = ok ? blockCount(s, l) : 0;
    bit expFail = ok && failAt >= 0 && failAt < expN;
    longint a = s;
    int k = 0;
    int guard = 0;
    @(negedge clk);
    reqStart = s[31:0];
    reqLen   = l[31:0];
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (!ok) begin
      chk(statusInvalid && !statusDone && !statusFailed, {tag, " R1/R2/R3 reject"},
          {statusDone, statusInvalid, statusFailed}, 3'b010);
      chk(!eraseReq && reqReady, {tag, " R2 no erase on reject"}, eraseReq, 0);
    end else begin
      if (expN > 0)
        chk({statusDone, statusInvalid, statusFailed} == 3'b000, {tag, " R9 clear on accept"},
            {statusDone, statusInvalid, statusFailed}, 0);
      while (!reqReady && guard < 400) begin
        guard++;
        chk(eraseReq && eraseAddr == a[31:0], {tag, " R4/R5 command address"}, eraseAddr, a);
        begin
          int w = $urandom_range(0, 2);
          for (int i = 0; i < w; i++) begin
            @(negedge clk);
            chk(eraseReq && eraseAddr == a[31:0], {tag, " R10 hold while waiting"}, eraseAddr, a);
          end
        end
        eraseAck  = 1'b1;
        eraseFail = (k == failAt);
        @(negedge clk);
        eraseAck  = 1'b0;
        eraseFail = 1'b0;
        a += blk(a);
        k++;
      end
      if (expFail) begin
        chk(k == failAt + 1, {tag, " R6 commands before stop"}, k, failAt + 1);
        chk(statusFailed && !statusDone && !statusInvalid, {tag, " R6 failed status"},
            {statusDone, statusInvalid, statusFailed}, 3'b001);
      end else begin
        chk(k == expN, {tag, " R7/R8 command count"}, k, expN);
        chk(statusDone && !statusInvalid && !statusFailed, {tag, " R7/R8 done status"},
            {statusDone, statusInvalid, statusFailed}, 3'b100);
      end
    end
    begin
      logic [2:0] st = {statusDone, statusInvalid, statusFailed};
      repeat (3) @(negedge clk);
      chk({statusDone, statusInvalid, statusFailed} == st && !eraseReq && reqReady,
          {tag, " R9 status held"}, {statusDone, statusInvalid, statusFailed}, st);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(reqReady && !eraseReq && !statusDone && !statusInvalid && !statusFailed,
        "R11 reset state", {reqReady, eraseReq, statusDone, statusInvalid, statusFailed}, 5'b10000);
    rst_n = 1'b1;

    doReq(64'h0, 64'h0, -1, "zero len R8");
    doReq(64'h4000, 64'h4000, -1, "one small block R4");
    doReq(64'h0, 64'h400000, -1, "whole device R5");
    doReq(64'h1C000, 64'h24000, -1, "cross boundary R5");
    doReq(64'h10000, 64'h10000, -1, "end at boundary R3");
    doReq(64'h1C000, 64'h8000, -1, "end misaligned upper R3");
    doReq(64'h0, 64'h6000, -1, "end misaligned lower R3");
    doReq(64'h24000, 64'h20000, -1, "start misaligned upper R2");
    doReq(64'h2000, 64'h2000, -1, "start misaligned lower R2");
    doReq(64'h3E0000, 64'h40000, -1, "over size R1");
    doReq(64'hFFFFFFFF, 64'h2, -1, "wrap sum R1");
    doReq(64'h3E0000, 64'h20000, -1, "last block R7");
    doReq(64'h0, 64'h60000, 2, "fail mid R6");
    doReq(64'h3E0000, 64'h20000, 0, "fail single last R6");
    doReq(64'h18000, 64'h28000, 2, "fail last crossing R6");

    for (int n = 0; n < 40; n++) begin
      int bi = $urandom_range(0, 38);
      int nb = $urandom_range(0, 39 - bi);
      longint s = (bi < 8) ? longint'(bi) * 64'h4000 : BOUND + longint'(bi - 8) * 64'h20000;
      longint l = 0;
      longint a = s;
      int fa = -1;
      for (int j = 0; j < nb; j++) begin
        l += blk(a);
        a += blk(a);
      end
      if ($urandom_range(0, 4) == 0) l += 64'h4000;
      if ($urandom_range(0, 6) == 0) s += 64'h4000;
      if ($urandom_range(0, 3) == 0 && nb > 0) fa = $urandom_range(0, nb - 1);
      doReq(s, l, fa, "random R4/R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule